// File: doc/BRIEF.md
# Joypad Matrix Register with Keypad Interrupt

This block is the memory-mapped key-matrix register of a small handheld-style system. Software writes a two-bit selector into the register. A read then returns the state of the selected key group in the low nibble, with a pressed key reading as 0. The block takes an 8-bit raw key vector and a controller index from outside. In the raw vector the direction keys sit in the upper nibble and the action buttons in the lower nibble, and 1 means pressed. The CPU bus decoder and the interrupt controller sit outside this block.

The key lines are re-evaluated on every clock. A key that becomes pressed on the visible group raises a one-cycle interrupt request without any bus access. An option input hides physically impossible direction pairs from software, so that left with right, or up with down, reads as released.

Top module: `keypad_matrix_port`

## Requirements
- R1: After reset the read value is 0xFF and the interrupt output is low.
- R2: A write stores only write-data bits 5:4 as the selector, and it shows on read bits 5:4 from the next cycle. Bits 7:6 always read 1. The written low nibble has no effect on the read value. Without a write, the selector holds.
- R3: With selector 2'b10, read bits 3:0 are the inverse of raw key bits 7:4.
- R4: With selector 2'b01, read bits 3:0 are the inverse of raw key bits 3:0.
- R5: With selector 2'b00, read bits 3:0 are the inverse of the bitwise OR of the two raw key nibbles.
- R6: With selector 2'b11, read bits 3:0 are the inverse of the controller index, zero-extended to four bits.
- R7: While the controller index is nonzero, the raw keys count as all released for selectors 2'b00, 2'b01 and 2'b10.
- R8: When any unfiltered low-nibble line goes from 1 to 0, the interrupt output is high for exactly the following cycle. A line that rises or stays the same raises no request.
- R9: With selector 2'b10 and suppression enabled, read bits 1:0 become 2'b11 if both read 0, and read bits 3:2 become 2'b11 if both read 0.
- R10: With suppression disabled, or with any selector other than 2'b10, both pressed lines of a pair still read 0.
- R11: The read value and the interrupt react one clock after a key or controller change, even when no write occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; bits 5:4 are the selector |
| keys_raw | input | 8 | Raw keys, 1 = pressed; [7:4] directions, [3:0] buttons |
| ctrl_idx | input | 2 | Current controller index |
| opp_mask_en | input | 1 | Enable opposing-direction suppression |
| rd_data | output | 8 | Register read value |
| irq_pulse | output | 1 | Keypad interrupt request, one-cycle pulse |

## Verification
The block's only state is the stored selector and the registered unfiltered line nibble. A corrupted selector shows on read bits 5:4 and on the group shown in the low nibble in the cycle after the write. A corrupted line register shows in the low nibble at once. It also shows as a missing or spurious interrupt pulse on the edge that follows, because the falling-edge test compares that register with the next value. The sweep covers every selector, key vector, controller index and suppression setting. After each step it checks both the cycle with the write and the quiet cycle that follows, so a stuck or stretched pulse shows within one cycle.

// File: rtl/keypad_pkg.sv
package keypad_pkg;

   typedef enum logic [1:0] {
      KP_SEL_BOTH = 2'b00,
      KP_SEL_BTN  = 2'b01,
      KP_SEL_DIR  = 2'b10,
      KP_SEL_CTRL = 2'b11
   } kp_sel_e;

   localparam int KP_SEL_W = 2;

endpackage

// File: rtl/keypad_sel_reg.sv
module keypad_sel_reg
   import keypad_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int SEL_LSB = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output kp_sel_e           sel_q,
   output kp_sel_e           sel_next
);

   if (SEL_LSB + KP_SEL_W > DATA_W) begin : g_bad_lsb
      $error("selector field exceeds data width");
   end

   always_comb begin
      if (wr_en) sel_next = kp_sel_e'(wr_data[SEL_LSB +: KP_SEL_W]);
      else       sel_next = sel_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) sel_q <= KP_SEL_CTRL;
      else        sel_q <= sel_next;
   end

endmodule

// File: rtl/keypad_nibble_sel.sv
module keypad_nibble_sel
   import keypad_pkg::*;
#(
   parameter int NIB_W  = 4,
   parameter int CTRL_W = 2
) (
   input  kp_sel_e             sel,
   input  logic [2*NIB_W-1:0]  keys_raw,
   input  logic [CTRL_W-1:0]   ctrl_idx,
   output logic [NIB_W-1:0]    pressed
);

   logic [2*NIB_W-1:0] keys_eff;
   logic [NIB_W-1:0]   grp_dir;
   logic [NIB_W-1:0]   grp_btn;

   // a nonzero controller index hides the local keys
   assign keys_eff = (ctrl_idx != '0) ? '0 : keys_raw;
   assign grp_dir  = keys_eff[2*NIB_W-1:NIB_W];
   assign grp_btn  = keys_eff[NIB_W-1:0];

   always_comb begin
      unique case (sel)
         KP_SEL_DIR:  pressed = grp_dir;
         KP_SEL_BTN:  pressed = grp_btn;
         KP_SEL_BOTH: pressed = grp_dir | grp_btn;
         default:     pressed = NIB_W'(ctrl_idx);
      endcase
   end

endmodule

// File: rtl/keypad_fall_detect.sv
module keypad_fall_detect #(
   parameter int NIB_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NIB_W-1:0] lvl_next,
   output logic [NIB_W-1:0] lvl_q,
   output logic             fall_pulse
);

   logic [NIB_W-1:0] falls;

   assign falls = lvl_q & ~lvl_next;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q      <= '1;
         fall_pulse <= 1'b0;
      end else begin
         lvl_q      <= lvl_next;
         fall_pulse <= |falls;
      end
   end

endmodule

// File: rtl/keypad_oppose_filt.sv
module keypad_oppose_filt
   import keypad_pkg::*;
#(
   parameter int NIB_W  = 4,
   parameter bit ENABLE = 1'b1
) (
   input  kp_sel_e          sel,
   input  logic             opp_en,
   input  logic [NIB_W-1:0] lvl_in,
   output logic [NIB_W-1:0] lvl_out
);

   localparam int PAIRS = NIB_W / 2;

   if (NIB_W % 2 != 0) begin : g_bad_nib
      $error("line nibble must hold whole pairs");
   end

   if (ENABLE) begin : g_filter
      logic active;
      assign active = opp_en && (sel == KP_SEL_DIR);
      for (genvar p = 0; p < PAIRS; p++) begin : g_pair
         always_comb begin
            if (active && (lvl_in[2*p +: 2] == 2'b00)) lvl_out[2*p +: 2] = 2'b11;
            else                                       lvl_out[2*p +: 2] = lvl_in[2*p +: 2];
         end
      end
   end else begin : g_pass
      logic unused_in;
      assign unused_in = opp_en ^ (^sel);
      assign lvl_out   = lvl_in;
   end

endmodule

// File: rtl/keypad_matrix_port.sv
module keypad_matrix_port
   import keypad_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int NIB_W          = 4,
   parameter int CTRL_W         = 2,
   parameter int SEL_LSB        = 4,
   parameter bit HAS_OPP_FILTER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] keys_raw,
   input  logic [CTRL_W-1:0] ctrl_idx,
   input  logic              opp_mask_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq_pulse
);

   if (DATA_W != 2 * NIB_W) begin : g_bad_width
      $error("key vector must be two nibbles");
   end
   if (CTRL_W > NIB_W) begin : g_bad_ctrl
      $error("controller index wider than line nibble");
   end
   if (SEL_LSB < NIB_W) begin : g_bad_sel
      $error("selector overlaps the line nibble");
   end

   kp_sel_e          sel_q;
   kp_sel_e          sel_next;
   logic [NIB_W-1:0] pressed;
   logic [NIB_W-1:0] lvl_next;
   logic [NIB_W-1:0] lvl_q;
   logic [NIB_W-1:0] lvl_shown;

   keypad_sel_reg #(.DATA_W(DATA_W), .SEL_LSB(SEL_LSB)) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .sel_q    (sel_q),
      .sel_next (sel_next)
   );

   keypad_nibble_sel #(.NIB_W(NIB_W), .CTRL_W(CTRL_W)) u_mux (
      .sel      (sel_next),
      .keys_raw (keys_raw),
      .ctrl_idx (ctrl_idx),
      .pressed  (pressed)
   );

   assign lvl_next = ~pressed;

   keypad_fall_detect #(.NIB_W(NIB_W)) u_fall (
      .clk        (clk),
      .rst_n      (rst_n),
      .lvl_next   (lvl_next),
      .lvl_q      (lvl_q),
      .fall_pulse (irq_pulse)
   );

   keypad_oppose_filt #(.NIB_W(NIB_W), .ENABLE(HAS_OPP_FILTER)) u_opp (
      .sel     (sel_q),
      .opp_en  (opp_mask_en),
      .lvl_in  (lvl_q),
      .lvl_out (lvl_shown)
   );

   always_comb begin
      rd_data                     = '1;
      rd_data[SEL_LSB +: KP_SEL_W] = sel_q;
      rd_data[NIB_W-1:0]          = lvl_shown;
   end

endmodule

// File: rtl/keypad_matrix_port_chk.sv
module keypad_matrix_port_chk #(
   parameter int DATA_W         = 8,
   parameter int NIB_W          = 4,
   parameter int CTRL_W         = 2,
   parameter int SEL_LSB        = 4,
   parameter bit HAS_OPP_FILTER = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] keys_raw,
   input logic [CTRL_W-1:0] ctrl_idx,
   input logic              opp_mask_en,
   input logic [DATA_W-1:0] rd_data,
   input logic              irq_pulse,
   input logic [NIB_W-1:0]  lvl_q
);

   logic [NIB_W-1:0] ctrl_pad;
   assign ctrl_pad = NIB_W'(ctrl_idx);

   AST_SEL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rd_data[SEL_LSB +: 2] == $past(wr_data[SEL_LSB +: 2])); // R2
   AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(rd_data[SEL_LSB +: 2])); // R2
   AST_CTRL_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && rd_data[SEL_LSB +: 2] == 2'b11) |=> rd_data[NIB_W-1:0] == ~$past(ctrl_pad)); // R6
   AST_DIR_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && rd_data[SEL_LSB +: 2] == 2'b10 && ctrl_idx == '0)
      |=> (opp_mask_en || rd_data[NIB_W-1:0] == ~$past(keys_raw[DATA_W-1:NIB_W]))); // R3
   AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> (|($past(lvl_q) & ~lvl_q))); // R8

   if (HAS_OPP_FILTER) begin : g_opp_chk
      AST_NO_OPPOSED: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_data[SEL_LSB +: 2] == 2'b10 && opp_mask_en)
         |-> (rd_data[1:0] != 2'b00 && rd_data[3:2] != 2'b00)); // R9
   end

endmodule

bind keypad_matrix_port keypad_matrix_port_chk #(
   .DATA_W(DATA_W), .NIB_W(NIB_W), .CTRL_W(CTRL_W),
   .SEL_LSB(SEL_LSB), .HAS_OPP_FILTER(HAS_OPP_FILTER)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_data     (wr_data),
   .keys_raw    (keys_raw),
   .ctrl_idx    (ctrl_idx),
   .opp_mask_en (opp_mask_en),
   .rd_data     (rd_data),
   .irq_pulse   (irq_pulse),
   .lvl_q       (lvl_q)
);

// File: tb/test_keypad_matrix_port.sv
module test_keypad_matrix_port;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] keys_raw = '0;
   logic [1:0] ctrl_idx = '0;
   logic       opp_mask_en = 1'b0;
   logic [7:0] rd_data;
   logic       irq_pulse;

   int checks = 0;
   int errors = 0;
   logic [3:0] prev_lvl = 4'hF;

   always #5 clk = ~clk;

   keypad_matrix_port i_keypad_matrix_port (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .keys_raw(keys_raw), .ctrl_idx(ctrl_idx), .opp_mask_en(opp_mask_en),
      .rd_data(rd_data), .irq_pulse(irq_pulse)
   );

   // unfiltered active-low line nibble per R3..R7
   function automatic logic [3:0] model_lvl(logic [1:0] s, logic [7:0] k, logic [1:0] c);
      logic [7:0] e;
      logic [3:0] p;
      e = (c != 0) ? 8'h00 : k;
      case (s)
         2'b10:   p = e[7:4];
         2'b01:   p = e[3:0];
         2'b00:   p = e[7:4] | e[3:0];
         default: p = {2'b00, c};
      endcase
      return ~p;
   endfunction

   // read value per R2, R9, R10
   function automatic logic [7:0] model_rd(logic [1:0] s, logic [3:0] l, logic o);
      logic [3:0] n;
      n = l;
      if (s == 2'b10 && o) begin
         if (n[1:0] == 2'b00) n[1:0] = 2'b11;
         if (n[3:2] == 2'b00) n[3:2] = 2'b11;
      end
      return {2'b11, s, n};
   endfunction

   function automatic string sel_tag(logic [1:0] s, logic [1:0] c, logic o);
      if (c != 0 && s != 2'b11) return "R7";
      case (s)
         2'b10:   return o ? "R9" : "R3";
         2'b01:   return "R4";
         2'b00:   return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // called at a negedge; leaves at a negedge
   task automatic step(logic [1:0] s, logic [7:0] k, logic [1:0] c, logic o);
      logic [3:0] lvl;
      logic       exp_irq;
      wr_en       = 1'b1;
      wr_data     = {k[7:6] ^ 2'b10, s, k[3:0] ^ 4'h5};   // R2: junk outside 5:4
      keys_raw    = k;
      ctrl_idx    = c;
      opp_mask_en = o;
      lvl     = model_lvl(s, k, c);
      exp_irq = |(prev_lvl & ~lvl);
      @(negedge clk);
      wr_en = 1'b0;
      check(sel_tag(s, c, o), {irq_pulse, rd_data}, {exp_irq, model_rd(s, lvl, o)}); // R2 R8
      prev_lvl = lvl;
      @(negedge clk);
      check("R8", {irq_pulse, rd_data}, {1'b0, model_rd(s, lvl, o)});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1", {irq_pulse, rd_data}, {1'b0, 8'hFF});
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", {irq_pulse, rd_data}, {1'b0, 8'hFF});

      // exhaustive sweep: R2..R10
      for (int o = 0; o < 2; o++)
         for (int c = 0; c < 4; c++)
            for (int s = 0; s < 4; s++)
               for (int k = 0; k < 256; k++)
                  step(2'(s), 8'(k), 2'(c), 1'(o));

      // R11: press without any write raises the request one cycle later
      step(2'b01, 8'h00, 2'b00, 1'b0);
      keys_raw = 8'h04;
      @(negedge clk);
      check("R11", {irq_pulse, rd_data}, {1'b1, 8'hDB});
      @(negedge clk);
      check("R11", {irq_pulse, rd_data}, {1'b0, 8'hDB});
      keys_raw = 8'h00;   // release: no request (R8)
      @(negedge clk);
      check("R8", {irq_pulse, rd_data}, {1'b0, 8'hDF});
      // R10: other selector keeps both pressed opposing buttons low
      opp_mask_en = 1'b1;
      keys_raw    = 8'h03;
      @(negedge clk);
      check("R10", {irq_pulse, rd_data}, {1'b1, 8'hDC});

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule